// File: doc/BRIEF.md
# Random-Dwell Lamp Guessing Game Controller

A synchronous Moore state machine that runs a four-lamp guessing game. In play, exactly one of four lamps is lit and the lit position rotates from lamp 1 to lamp 4 and back to lamp 1. The player presses the button that sits next to the lamp believed to be lit. The block then shows a success or an error result, and it holds that result until every button is up again.

The clock runs at three times the base game rate. The lit lamp moves on only in cycles where an internal pseudorandom enable is high, so the time each lamp stays lit varies from one step to the next. The enable comes from an 8-bit maximal-length shift register. The buttons are sampled on every clock and are assumed to be already debounced and synchronous to `clk`.

Top module: `guess_game_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are `lamp`=4'b0001 and `err`=0, and the pseudorandom register is loaded with 8'h01.
- R2: With no button pressed in a lamp-lit state, the lit lamp moves one place at the edge that ends a cycle whose advance enable is high. The order is lamp bit 0, 1, 2, 3, then 0 again. The lamp does not move at the edge that ends a cycle whose enable is low.
- R3: The pseudorandom register shifts left on every clock. The bit shifted in is the XOR of bits 7, 5, 4 and 3. An all-zero value is replaced by 8'h01. The advance enable is the AND of bits 0 and 1.
- R4: If `btn` equals the lit lamp pattern (`btn[i]` is the button next to `lamp[i]`), the next outputs are all lamps off with `err`=0. This is the success result.
- R5: If `btn` is non-zero but differs from the lit lamp pattern, the next outputs are all lamps off with `err`=1. This covers a wrong single button and any press of two or more buttons.
- R6: Once a success or error result is shown, it is held unchanged while any button is pressed. At the edge after `btn` returns to 4'b0000, play restarts with `lamp`=4'b0001 and `err`=0.
- R7: Buttons are judged on every cycle whatever the advance enable. A press takes precedence over an advance in the same cycle.
- R8: At most one of the five outputs {`err`, `lamp`} is high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, three times the base game rate |
| rst_n | input | 1 | Synchronous reset, active low |
| btn | input | 4 | Button levels; bit i is the button beside lamp i |
| lamp | output | 4 | Lamp lines; at most one lit |
| err | output | 1 | High while an error result is held |

## Verification
The assertions take for granted that `btn` is clean and synchronous, so a press pattern is stable for a whole clock period and is judged once per edge. The stimulus changes `btn` only on falling edges. It holds each press pattern for a random one to four cycles, and each press is either the exactly matching button or a random non-zero pattern. This reaches both results with presses that fall in enable-high and enable-low cycles alike. Releases, single-cycle holds and a mid-run reset are applied on purpose.

// File: rtl/guess_pkg.sv
// Package for the guessing game: state codes, lamp count and the
// helper functions that map states to lamps. Assumes four lamps.
package guess_pkg;

    localparam int NUM_LAMPS = 4;

    // Gray-style codes; the two remaining 3-bit codes are unused.
    typedef enum logic [2:0] {
        ST_S1  = 3'b000,
        ST_S2  = 3'b001,
        ST_S4  = 3'b010,
        ST_S3  = 3'b011,
        ST_OK  = 3'b100,
        ST_ERR = 3'b101
    } gstate_t;

    // Lamp pattern shown by a play state; zero for result states.
    function automatic logic [NUM_LAMPS-1:0] state_lamps(gstate_t s);
        case (s)
            ST_S1:   return 4'b0001;
            ST_S2:   return 4'b0010;
            ST_S3:   return 4'b0100;
            ST_S4:   return 4'b1000;
            default: return 4'b0000;
        endcase
    endfunction

    // Next play state in the rotation.
    function automatic gstate_t step_next(gstate_t s);
        case (s)
            ST_S1:   return ST_S2;
            ST_S2:   return ST_S3;
            ST_S3:   return ST_S4;
            default: return ST_S1;
        endcase
    endfunction

    // Play state that lights lamp index i.
    function automatic gstate_t lamp_code(int i);
        case (i)
            0:       return ST_S1;
            1:       return ST_S2;
            2:       return ST_S3;
            default: return ST_S4;
        endcase
    endfunction

endpackage

// File: rtl/guess_lfsr.sv
// Fibonacci shift register that produces the random advance enable.
// It shifts every clock and never stays at zero. Assumes W >= 2.
module guess_lfsr #(
    parameter int          W     = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'h01,
    parameter int          EN_A  = 0,
    parameter int          EN_B  = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic adv_en
);

    logic [W-1:0] q;
    logic [W-1:0] q_next;

    // Shift with the XOR of the tapped bits fed into bit 0.
    assign q_next = {q[W-2:0], ^(q & TAPS)};

    // Register update: seed on reset and escape from the zero lock-up value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= SEED;
        else if (q == '0)
            q <= SEED;
        else
            q <= q_next;
    end

    assign adv_en = q[EN_A] & q[EN_B];

endmodule

// File: rtl/guess_fsm.sv
// Game state register and next-state logic. Buttons are judged every
// cycle; the rotation steps only when adv_en is high. Unused codes
// return to the first play state.
module guess_fsm
    import guess_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LAMPS-1:0] btn,
    input  logic                 adv_en,
    output gstate_t              state
);

    gstate_t nxt;
    logic    any_btn;
    logic    hit;

    assign any_btn = |btn;
    assign hit     = (btn == state_lamps(state));

    // Next state: a press beats an advance; results wait for release.
    always_comb begin
        nxt = state;
        case (state)
            ST_S1, ST_S2, ST_S3, ST_S4: begin
                if (any_btn)
                    nxt = hit ? ST_OK : ST_ERR;
                else if (adv_en)
                    nxt = step_next(state);
            end
            ST_OK, ST_ERR: begin
                if (!any_btn)
                    nxt = ST_S1;
            end
            default: nxt = ST_S1;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_S1;
        else
            state <= nxt;
    end

endmodule

// File: rtl/guess_decode.sv
// Moore output decode: each lamp from its own play-state code and the
// error line from the error-state code only.
module guess_decode
    import guess_pkg::*;
(
    input  gstate_t              state,
    output logic [NUM_LAMPS-1:0] lamp,
    output logic                 err
);

    // One comparator per lamp.
    for (genvar i = 0; i < NUM_LAMPS; i++) begin : g_lamp
        assign lamp[i] = (state == lamp_code(i));
    end

    assign err = (state == ST_ERR);

endmodule

// File: rtl/guess_game_top.sv
// Top of the random-dwell guessing game. Assumes btn is debounced and
// synchronous to clk; reset is synchronous and active low.
module guess_game_top (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] btn,
    output logic [3:0] lamp,
    output logic       err
);
    import guess_pkg::*;

    logic    adv_en;
    gstate_t state;

    guess_lfsr #(
        .W    (8),
        .TAPS (8'hB8),
        .SEED (8'h01),
        .EN_A (0),
        .EN_B (1)
    ) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_en (adv_en)
    );

    guess_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .btn    (btn),
        .adv_en (adv_en),
        .state  (state)
    );

    guess_decode u_dec (
        .state (state),
        .lamp  (lamp),
        .err   (err)
    );

endmodule

// File: rtl/guess_game_chk.sv
// Checker for the guessing game, bound to the top. Assumes btn is
// stable across each clock period.
module guess_game_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] btn,
    input logic [3:0] lamp,
    input logic       err,
    input logic       adv_en
);

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (lamp == 4'b0001) && !err);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|lamp) && (btn == 4'b0000) && adv_en)
        |=> lamp == {$past(lamp[2:0]), $past(lamp[3])});

    p_dwell_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|lamp) && (btn == 4'b0000) && !adv_en) |=> $stable(lamp));

    p_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|lamp) && (btn == lamp)) |=> (lamp == 4'b0000) && !err);

    p_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|lamp) && (btn != 4'b0000) && (btn != lamp)) |=> (lamp == 4'b0000) && err);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((lamp == 4'b0000) && (btn != 4'b0000)) |=> (lamp == 4'b0000) && $stable(err));

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((lamp == 4'b0000) && (btn == 4'b0000)) |=> (lamp == 4'b0001) && !err);

    p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err, lamp}));

endmodule

bind guess_game_top guess_game_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .btn    (btn),
    .lamp   (lamp),
    .err    (err),
    .adv_en (adv_en)
);

// File: tb/guess_game_top_bench.sv
// Bench: random presses plus directed cases, checked against a model
// built from the requirements.
module guess_game_top_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] btn;
    logic [3:0] lamp;
    logic       err;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    logic [7:0] m_lfsr;
    logic [3:0] m_lamp;
    logic       m_err;
    string      m_tag;

    int         press_left = 0;
    logic [3:0] press_pat  = 4'b0000;

    always #5 clk = ~clk;

    guess_game_top u_guess_game_top (
        .clk   (clk),
        .rst_n (rst_n),
        .btn   (btn),
        .lamp  (lamp),
        .err   (err)
    );

    // Compare one value and report a failure.
    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Model the next outputs from the requirements (R1..R7).
    task automatic model_edge(input logic rn, input logic [3:0] b);
        logic en;
        en = m_lfsr[0] & m_lfsr[1];
        if (!rn) begin
            m_lamp = 4'b0001; m_err = 1'b0; m_lfsr = 8'h01; m_tag = "R1";
            return;
        end
        if (m_lamp != 4'b0000) begin
            if (b != 4'b0000) begin
                if (b == m_lamp) begin
                    m_tag = en ? "R4" : "R4 R7";
                    m_err = 1'b0;
                end else begin
                    m_tag = en ? "R5" : "R5 R7";
                    m_err = 1'b1;
                end
                m_lamp = 4'b0000;
            end else if (en) begin
                m_lamp = {m_lamp[2:0], m_lamp[3]};
                m_tag = "R2 R3 advance";
            end else begin
                m_tag = "R2 R3 dwell";
            end
        end else begin
            if (b == 4'b0000) begin
                m_lamp = 4'b0001; m_err = 1'b0; m_tag = "R6 release";
            end else begin
                m_tag = "R6 hold";
            end
        end
        m_lfsr = {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
        if (m_lfsr == 8'h00) m_lfsr = 8'h01;
    endtask

    // Drive one cycle at a falling edge, then check at the next one.
    task automatic cycle(input logic rn, input logic [3:0] b);
        rst_n = rn;
        btn   = b;
        model_edge(rn, b);
        @(negedge clk);
        check(m_tag, {err, lamp}, {m_err, m_lamp});
        total++;
        if (!$onehot0({err, lamp})) begin
            bad++;
            $display("FAIL R8 actual=%b expected=onehot0", {err, lamp});
        end
    endtask

    initial begin
        void'($urandom(32'h5EED));
        rst_n = 1'b0;
        btn   = 4'b0000;
        m_lfsr = 8'h01; m_lamp = 4'b0001; m_err = 1'b0; m_tag = "R1";
        repeat (3) cycle(1'b0, 4'b0000);

        // Directed: correct press on the first lamp, held, released.
        cycle(1'b1, 4'b0001);
        cycle(1'b1, 4'b0001);
        cycle(1'b1, 4'b0000);
        // Directed: two buttons at once, held two cycles, released.
        cycle(1'b1, 4'b0011);
        cycle(1'b1, 4'b0010);
        cycle(1'b1, 4'b0010);
        cycle(1'b1, 4'b0000);
        // Directed: all four buttons.
        cycle(1'b1, 4'b1111);
        cycle(1'b1, 4'b0000);
        // Let the lamp rotate for a while.
        repeat (40) cycle(1'b1, 4'b0000);

        // Random play.
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] b;
            if (n == 1500) begin
                cycle(1'b0, 4'b0100);
                press_left = 0;
                continue;
            end
            if (press_left > 0) begin
                b = press_pat;
                press_left--;
            end else if (($urandom % 8) == 0) begin
                if ((($urandom % 2) == 0) && (m_lamp != 4'b0000))
                    press_pat = m_lamp;
                else
                    press_pat = 4'(1 + ($urandom % 15));
                b = press_pat;
                press_left = int'($urandom % 4);
            end else begin
                b = 4'b0000;
            end
            cycle(1'b1, b);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule